// File: doc/BRIEF.md
# Cascadable Event Counter Pair

This block holds two 40-bit event counters for a core that runs two hardware threads. Each counter has its own event-increment input and its own control word. A counter counts only while its enable bit is set. It overflows when it wraps from all ones to zero, or on every counted increment while its force bit is set. After an overflow, the next counted event on that counter raises an interrupt. The interrupt goes to each thread whose interrupt-enable bit is set in that counter's control word. Each request line stays high until software rewrites the control word of the counter that raised it.

A counter can also be made to wait for its partner. With its cascade bit set, it ignores events until the other counter of the pair overflows. It then counts until its own control word is written again. This lets the pair act as one wider counter, or lets one counter start measuring once another event count has been reached.

Software reaches the block through a single-cycle write port. `wr_sel_i` picks the counter. `wr_ctl_i` picks between the count value (0) and the control word (1).

Top module: `evc_pair`

## Requirements
- R1: While reset is asserted, and after it is released, both request lines are low and both control words are clear. Assertion of `rst_n` takes effect without waiting for a clock edge.
- R2: Control bit 12 is the enable. A counter adds one on a cycle where its event input is high only while this bit is set. While it is clear, events leave the count unchanged.
- R3: An overflow occurs when a counter wraps from all ones to zero, and counting then continues from zero. The interrupt is raised on the next counted event after the overflow, never in the cycle of the wrap itself.
- R4: Control bit 25 is force-overflow. While it is set, every counted increment is an overflow, whatever the count value.
- R5: Control bit 26 routes a counter's interrupt to `irq_o[0]` and bit 27 routes it to `irq_o[1]`. A clear bit suppresses that route. Each line is the OR over both counters.
- R6: The overflow and interrupt state is sticky. Only a control-word write to that counter clears it, and it clears whatever bit 31 of the written data holds. A count-value write leaves it untouched.
- R7: Control bit 30 is cascade. A counter with it set ignores events until its partner overflows. It counts from the next cycle on, with no further partner overflow needed, until its control word is rewritten.
- R8: With the cascade bit clear, a counter counts on its own events regardless of its partner.
- R9: When a write to a counter and an event for that counter fall in the same cycle, the written value is kept and the event is lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| wr_sel_i | input | 1 | Target counter of the write (0 or 1) |
| wr_ctl_i | input | 1 | 1 writes the control word, 0 writes the count value |
| wr_data_i | input | 40 | Write data; control fields at bits 12, 25, 26, 27, 30 |
| ev_inc_i | input | 2 | Per-counter event increment, bit n for counter n |
| irq_o | output | 2 | Interrupt request, bit n for thread n |

## Verification
The enable, count, pending, armed and interrupt state are internal, so a fault in any of them shows only in the timing of the request lines. A count that is off by one moves the interrupt one counted event earlier or later. A pending state set too early raises the line in the wrap cycle instead of one event later. A cascade counter that is armed too early, or stays armed after a rewrite, raises a request that should never appear. Each such fault shows within two counted events of the wrap that exposes it. The bench therefore preloads counts next to all ones and checks the lines after every single cycle.

// File: rtl/evc_pkg.sv
package evc_pkg;
  localparam int CNT_W    = 40;
  localparam int NUM_CNT  = 2;
  localparam int NUM_THR  = 2;
  // control word field positions
  localparam int EN_BIT   = 12;
  localparam int FRC_BIT  = 25;
  localparam int IE_BASE  = 26;
  localparam int CAS_BIT  = 30;
  localparam int OVF_BIT  = 31;
endpackage

// File: rtl/evc_reset_sync.sv
module evc_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/evc_counter.sv
module evc_counter
  import evc_pkg::*;
#(
  parameter int W   = CNT_W,
  parameter int THR = NUM_THR
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_cnt_i,
  input  logic           wr_ctl_i,
  input  logic [W-1:0]   wr_data_i,
  input  logic           ev_i,
  input  logic           partner_ovf_i,
  output logic           ovf_evt_o,
  output logic           fire_o,
  output logic [THR-1:0] ie_o
);
  // count and control state
  logic [W-1:0]   cnt_q,  cnt_d;
  logic           en_q,   en_d;
  logic           frc_q,  frc_d;
  logic           cas_q,  cas_d;
  logic [THR-1:0] ie_q,   ie_d;
  // overflow bookkeeping
  logic           ovf_q,  ovf_d;
  logic           pend_q, pend_d;
  logic           fire_q, fire_d;
  logic           arm_q,  arm_d;

  logic wr_any, run, inc, wrap, ovf_evt, cnt_ce;

  assign wr_any  = wr_cnt_i | wr_ctl_i;
  assign run     = en_q & (~cas_q | arm_q);
  assign inc     = ev_i & run & ~wr_any;
  assign wrap    = &cnt_q;
  assign ovf_evt = inc & (frc_q | wrap);
  assign cnt_ce  = wr_cnt_i | inc;

  always_comb begin
    cnt_d = wr_cnt_i ? wr_data_i : cnt_q + W'(1);
    if (wr_ctl_i) begin
      en_d   = wr_data_i[EN_BIT];
      frc_d  = wr_data_i[FRC_BIT];
      cas_d  = wr_data_i[CAS_BIT];
      ie_d   = wr_data_i[IE_BASE +: THR];
      ovf_d  = 1'b0;
      pend_d = 1'b0;
      fire_d = 1'b0;
      arm_d  = 1'b0;
    end else begin
      en_d   = en_q;
      frc_d  = frc_q;
      cas_d  = cas_q;
      ie_d   = ie_q;
      ovf_d  = ovf_q | ovf_evt;
      pend_d = inc ? ovf_evt : pend_q;
      fire_d = fire_q | (inc & pend_q);
      arm_d  = arm_q | (cas_q & partner_ovf_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      frc_q  <= 1'b0;
      cas_q  <= 1'b0;
      ie_q   <= '0;
      ovf_q  <= 1'b0;
      pend_q <= 1'b0;
      fire_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      en_q   <= en_d;
      frc_q  <= frc_d;
      cas_q  <= cas_d;
      ie_q   <= ie_d;
      ovf_q  <= ovf_d;
      pend_q <= pend_d;
      fire_q <= fire_d;
      arm_q  <= arm_d;
    end
  end

  assign ovf_evt_o = ovf_evt;
  assign fire_o    = fire_q;
  assign ie_o      = ie_q;

  // R2
  en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !wr_any) |=> $stable(cnt_q));

  // R3
  wrap_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && !pend_q && !fire_q) |=> !fire_q);

  // R4
  force_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && frc_q) |=> ovf_q);

  // R6
  sticky_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_q && !wr_ctl_i) |=> fire_q);

  // R7
  cascade_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && cas_q && !arm_q && !wr_any) |=> $stable(cnt_q));

  // R9
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt_i |=> (cnt_q == $past(wr_data_i)));
endmodule

// File: rtl/evc_irq_route.sv
module evc_irq_route #(
  parameter int CNT = 2,
  parameter int THR = 2
) (
  input  logic [CNT-1:0]          fire_i,
  input  logic [CNT-1:0][THR-1:0] ie_i,
  output logic [THR-1:0]          irq_o
);
  for (genvar t = 0; t < THR; t++) begin : g_thr
    logic [CNT-1:0] hit;
    for (genvar c = 0; c < CNT; c++) begin : g_cnt
      assign hit[c] = fire_i[c] & ie_i[c][t];
    end
    assign irq_o[t] = |hit;
  end
endmodule

// File: rtl/evc_pair.sv
module evc_pair
  import evc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en_i,
  input  logic               wr_sel_i,
  input  logic               wr_ctl_i,
  input  logic [CNT_W-1:0]   wr_data_i,
  input  logic [NUM_CNT-1:0] ev_inc_i,
  output logic [NUM_THR-1:0] irq_o
);
  logic                           rst_sync_n;
  logic [NUM_CNT-1:0]             ovf_evt;
  logic [NUM_CNT-1:0]             fire;
  logic [NUM_CNT-1:0][NUM_THR-1:0] ie;

  evc_reset_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_sync_n)
  );

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    logic hit;
    assign hit = wr_en_i & (wr_sel_i == 1'(i));

    evc_counter #(.W(CNT_W), .THR(NUM_THR)) u_cnt (
      .clk           (clk),
      .rst_n         (rst_sync_n),
      .wr_cnt_i      (hit & ~wr_ctl_i),
      .wr_ctl_i      (hit & wr_ctl_i),
      .wr_data_i     (wr_data_i),
      .ev_i          (ev_inc_i[i]),
      .partner_ovf_i (ovf_evt[i ^ 1]),
      .ovf_evt_o     (ovf_evt[i]),
      .fire_o        (fire[i]),
      .ie_o          (ie[i])
    );
  end

  evc_irq_route #(.CNT(NUM_CNT), .THR(NUM_THR)) u_route (
    .fire_i (fire),
    .ie_i   (ie),
    .irq_o  (irq_o)
  );
endmodule

// File: tb/tb_evc_pair.sv
module tb_evc_pair;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en_i = 1'b0;
  logic        wr_sel_i = 1'b0;
  logic        wr_ctl_i = 1'b0;
  logic [39:0] wr_data_i = '0;
  logic [1:0]  ev_inc_i = '0;
  logic [1:0]  irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  evc_pair dut (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_ctl_i(wr_ctl_i), .wr_data_i(wr_data_i), .ev_inc_i(ev_inc_i),
    .irq_o(irq_o)
  );

  localparam logic [39:0] ALL1 = {40{1'b1}};
  localparam logic [39:0] NEAR = ALL1 - 40'd1;
  localparam logic [39:0] ZERO = 40'h0;
  localparam logic [39:0] EN   = 40'h00_0000_1000;
  localparam logic [39:0] FRC  = 40'h00_0200_0000;
  localparam logic [39:0] IE0  = 40'h00_0400_0000;
  localparam logic [39:0] IE1  = 40'h00_0800_0000;
  localparam logic [39:0] CAS  = 40'h00_4000_0000;
  localparam logic [39:0] OVB  = 40'h00_8000_0000;

  typedef struct packed {
    logic        we;
    logic        sel;
    logic        ctl;
    logic [39:0] d;
    logic [1:0]  ev;
    logic [1:0]  exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 53;
  localparam vec_t VEC [0:NV-1] = '{
    '{1'b1,1'b0,1'b0,NEAR,2'b00,2'b00,4'd2},        // R2 preload counter 0
    '{1'b1,1'b0,1'b1,EN|IE0,2'b00,2'b00,4'd2},
    '{1'b0,1'b0,1'b0,ZERO,2'b01,2'b00,4'd2},        // reaches all ones
    '{1'b0,1'b0,1'b0,ZERO,2'b01,2'b00,4'd3},        // R3 wrap, no irq yet
    '{1'b0,1'b0,1'b0,ZERO,2'b00,2'b00,4'd3},
    '{1'b0,1'b0,1'b0,ZERO,2'b01,2'b01,4'd3},        // R3 next event fires
    '{1'b0,1'b0,1'b0,ZERO,2'b01,2'b01,4'd6},        // R6 held
    '{1'b0,1'b0,1'b0,ZERO,2'b00,2'b01,4'd6},
    '{1'b1,1'b0,1'b0,ALL1,2'b00,2'b01,4'd6},        // count write keeps irq
    '{1'b1,1'b0,1'b1,EN|IE1|OVB,2'b00,2'b00,4'd6},  // control write clears
    '{1'b0,1'b0,1'b0,ZERO,2'b01,2'b00,4'd3},
    '{1'b0,1'b0,1'b0,ZERO,2'b01,2'b10,4'd5},        // R5 thread 1 route
    '{1'b1,1'b0,1'b1,EN|FRC,2'b00,2'b00,4'd5},
    '{1'b0,1'b0,1'b0,ZERO,2'b01,2'b00,4'd5},
    '{1'b0,1'b0,1'b0,ZERO,2'b01,2'b00,4'd5},        // R5 suppressed
    '{1'b1,1'b0,1'b1,EN|FRC|IE0,2'b00,2'b00,4'd4},
    '{1'b0,1'b0,1'b0,ZERO,2'b01,2'b00,4'd4},        // R4 forced overflow
    '{1'b0,1'b0,1'b0,ZERO,2'b01,2'b01,4'd4},
    '{1'b1,1'b0,1'b1,IE0,2'b00,2'b00,4'd2},         // R2 disabled
    '{1'b1,1'b0,1'b0,ALL1,2'b00,2'b00,4'd2},
    '{1'b0,1'b0,1'b0,ZERO,2'b01,2'b00,4'd2},
    '{1'b0,1'b0,1'b0,ZERO,2'b01,2'b00,4'd2},
    '{1'b1,1'b0,1'b1,EN|IE0,2'b00,2'b00,4'd2},
    '{1'b0,1'b0,1'b0,ZERO,2'b01,2'b00,4'd2},
    '{1'b0,1'b0,1'b0,ZERO,2'b01,2'b01,4'd2},        // count was held at all ones
    '{1'b1,1'b0,1'b1,ZERO,2'b00,2'b00,4'd6},
    '{1'b1,1'b1,1'b0,ALL1,2'b00,2'b00,4'd7},        // R7 cascade setup
    '{1'b1,1'b1,1'b1,EN|CAS|IE1,2'b00,2'b00,4'd7},
    '{1'b0,1'b0,1'b0,ZERO,2'b10,2'b00,4'd7},
    '{1'b0,1'b0,1'b0,ZERO,2'b10,2'b00,4'd7},        // unarmed: no count
    '{1'b1,1'b0,1'b0,ALL1,2'b00,2'b00,4'd7},
    '{1'b1,1'b0,1'b1,EN,2'b00,2'b00,4'd7},
    '{1'b0,1'b0,1'b0,ZERO,2'b01,2'b00,4'd7},        // partner overflows
    '{1'b0,1'b0,1'b0,ZERO,2'b10,2'b00,4'd7},
    '{1'b0,1'b0,1'b0,ZERO,2'b10,2'b10,4'd7},        // armed counter fires
    '{1'b1,1'b1,1'b1,EN|CAS|IE1,2'b00,2'b00,4'd7},  // rewrite disarms
    '{1'b1,1'b1,1'b0,ALL1,2'b00,2'b00,4'd7},
    '{1'b0,1'b0,1'b0,ZERO,2'b10,2'b00,4'd7},
    '{1'b0,1'b0,1'b0,ZERO,2'b10,2'b00,4'd7},
    '{1'b1,1'b1,1'b1,EN|IE1,2'b00,2'b00,4'd8},      // R8 independent
    '{1'b0,1'b0,1'b0,ZERO,2'b10,2'b00,4'd8},
    '{1'b0,1'b0,1'b0,ZERO,2'b10,2'b10,4'd8},
    '{1'b1,1'b1,1'b1,ZERO,2'b00,2'b00,4'd8},
    '{1'b1,1'b0,1'b0,ALL1,2'b00,2'b00,4'd9},        // R9 setup
    '{1'b1,1'b0,1'b1,EN|IE0,2'b00,2'b00,4'd9},
    '{1'b1,1'b0,1'b0,NEAR,2'b01,2'b00,4'd9},        // event lost
    '{1'b0,1'b0,1'b0,ZERO,2'b01,2'b00,4'd9},
    '{1'b0,1'b0,1'b0,ZERO,2'b01,2'b00,4'd9},
    '{1'b0,1'b0,1'b0,ZERO,2'b01,2'b01,4'd9},
    '{1'b1,1'b1,1'b0,ALL1,2'b00,2'b01,4'd5},
    '{1'b1,1'b1,1'b1,EN|IE0|IE1,2'b00,2'b01,4'd5},
    '{1'b0,1'b0,1'b0,ZERO,2'b10,2'b01,4'd5},
    '{1'b0,1'b0,1'b0,ZERO,2'b10,2'b11,4'd5}         // R5 both threads
  };

  task automatic check(input logic [1:0] exp, input int req, input string what);
    checks++;
    if (irq_o !== exp) begin
      fails++;
      $display("FAIL R%0d %s: irq=%b expected %b", req, what, irq_o, exp);
    end
  endtask

  task automatic step(input vec_t v);
    @(negedge clk);
    wr_en_i   = v.we;
    wr_sel_i  = v.sel;
    wr_ctl_i  = v.ctl;
    wr_data_i = v.d;
    ev_inc_i  = v.ev;
    @(posedge clk);
    #1;
    check(v.exp, int'(v.req), "vector");
  endtask

  task automatic idle();
    @(negedge clk);
    wr_en_i  = 1'b0;
    ev_inc_i = 2'b00;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 check(2'b00, 1, "R1 during reset");
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1 check(2'b00, 1, "R1 after release");

    for (int i = 0; i < NV; i++) step(VEC[i]);
    idle();

    // R1: asynchronous reset drops a held request at once
    #1 rst_n = 1'b0;
    #1 check(2'b00, 1, "R1 async assert");
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk) ev_inc_i = 2'b11;
    repeat (4) @(posedge clk);
    #1 check(2'b00, 1, "R1 control cleared");
    idle();

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule